// File: doc/BRIEF.md
# Cascaded PWM LED Driver Sequencer

This block controls a daisy chain of constant-current LED driver devices through a bit-serial link. A parameter sets the number of devices in the chain, and each device has sixteen channels. After reset the block waits for a settle interval. It then runs a one-time correction-programming phase: it streams a 6-bit current-correction word for every channel into the chain and latches the result.

After that phase, each request on `start` runs one grayscale frame. The block lowers the blank output and issues a fixed number of PWM reference clock pulses. On the earliest ticks of the frame it also shifts out a 12-bit intensity word for every channel, one bit per tick. At the end of the frame it raises blank and latches the new data.

The host provides the correction and intensity values through two combinational read ports. The block presents a channel index and the host returns that channel's word in the same cycle. A programmable half-period input sets the rate of the serial clock and the PWM clock relative to the system clock.

Top module: `led_chain_ctrl`

## Requirements
- R1: While reset is held, the outputs are: `ser_clk` 0, `pwm_clk` 0, `prog_sel` 1, `latch` 0, `blank` 1, `dc_prog` 0 and `busy` 1.
- R2: After reset, the serial clock stays idle for `SETTLE_TICKS` half-periods. Every correction bit is then clocked while `dc_prog` and `prog_sel` are both 1.
- R3: The correction phase produces exactly `N_DEV*16*6` rising edges on `ser_clk` before its latch. Channel word 0 is sent first, and each word is sent from bit 0 (LSB) upward.
- R4: After the last correction bit, `latch` pulses once and then `dc_prog` returns to 0. `busy` then falls, while `prog_sel` remains 1.
- R5: A frame starts when `start` is sampled high while `busy` is 0. In the cycle after that edge, `blank` is 0 and `busy` is 1. The frame then contains exactly `PWM_TICKS` rising edges of `pwm_clk`, all of them while `blank` is 0.
- R6: In a frame, the first `N_DEV*16*12` PWM ticks each carry one `ser_clk` rising edge, which coincides with the PWM rising edge. These ticks send channel word 0 first, LSB first. No further `ser_clk` edge occurs before the frame's latch.
- R7: At the end of a frame, `blank` rises before `latch` rises. `latch` stays high for two half-periods, and it is never high while `blank` is 0.
- R8: The first frame after correction programming drives `prog_sel` low at its start. That frame issues exactly one extra `ser_clk` pulse after its latch. Later frames issue none.
- R9: `busy` stays 1 until the latch, and the extra clock when one is due, have finished. A `start` pulse seen while `busy` is 1 has no effect: no further frame follows, and blank remains high.
- R10: Each half-period lasts `half_period` system cycles, and a value of 0 counts as 1. `ser_out` is stable for at least one system cycle before every rising edge of `ser_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | DIV_W | System cycles per half-period of the serial and PWM clocks |
| start | input | 1 | Request one grayscale frame |
| busy | output | 1 | High during initialisation and during a frame |
| dc_addr | output | $clog2(N_DEV*16+1) | Channel index for the correction read port |
| dc_word | input | 6 | Correction word for channel `dc_addr` |
| gs_addr | output | $clog2(N_DEV*16+1) | Channel index for the intensity read port |
| gs_word | input | 12 | Intensity word for channel `gs_addr` |
| ser_out | output | 1 | Serial data into the chain |
| ser_clk | output | 1 | Serial shift clock |
| latch | output | 1 | Transfers the shifted data into the devices |
| blank | output | 1 | High turns all outputs off and resets the PWM counters |
| prog_sel | output | 1 | Programming-select level to the chain |
| dc_prog | output | 1 | Selects the correction register as the shift target |
| pwm_clk | output | 1 | PWM reference clock |

## Verification
The bench builds the block with two devices, which gives 32 channels and 384 intensity bits per frame. It also uses the full 4096-tick frame and an 8-tick settle interval. These values let the shift phase end well inside a frame, so the bench can check that the serial clock stays silent for the rest of the frame. The half-period input changes between frames through 1, 3 and 0. This exposes the divided pulse widths, the zero-means-one rule and the latch width at more than one rate. Three consecutive frames separate the one-time extra clock from the ordinary frames that follow it.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

    typedef enum logic [4:0] {
        ST_SETTLE,
        ST_DC_LO,
        ST_DC_HI,
        ST_DC_END,
        ST_DC_LAT_ON,
        ST_DC_LAT_MID,
        ST_DC_LAT_OFF,
        ST_DC_EXIT,
        ST_IDLE,
        ST_GS_LO,
        ST_GS_HI,
        ST_GS_END,
        ST_LAT_ON,
        ST_LAT_MID,
        ST_LAT_OFF,
        ST_XTRA_HI,
        ST_XTRA_LO
    } lcc_state_e;

endpackage

// File: rtl/lcc_tick_div.sv
// Half-period tick generator: one-cycle tick every max(half,1) system cycles.
module lcc_tick_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim   = (half == '0) ? DIV_W'(1) : half;
        tick  = (cnt_q >= lim - DIV_W'(1));
        cnt_d = tick ? '0 : cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (cnt_q != '0)); // R10

endmodule

// File: rtl/lcc_word_ser.sv
// Walks a word array channel by channel, LSB first, one bit per advance.
module lcc_word_ser #(
    parameter int W  = 12,
    parameter int N  = 32,
    parameter int AW = $clog2(N + 1),
    parameter int BW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [W-1:0]  word,
    output logic [AW-1:0] addr,
    output logic          bit_o,
    output logic          last,
    output logic          done
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [BW-1:0] pos;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else if (adv) begin
            if (s_q.pos == BW'(W - 1)) begin
                s_d.pos  = '0;
                s_d.addr = s_q.addr + AW'(1);
            end else begin
                s_d.pos = s_q.pos + BW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr  = s_q.addr;
    assign bit_o = word[s_q.pos];
    assign last  = (s_q.addr == AW'(N - 1)) && (s_q.pos == BW'(W - 1));
    assign done  = (s_q.addr == AW'(N));

    AST_SER_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> !done); // R6
    AST_SER_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pos <= BW'(W - 1)); // R3

endmodule

// File: rtl/led_chain_ctrl.sv
module led_chain_ctrl
    import lcc_pkg::*;
#(
    parameter int N_DEV        = 2,
    parameter int CH_PER_DEV   = 16,
    parameter int GS_W         = 12,
    parameter int DC_W         = 6,
    parameter int PWM_TICKS    = 4096,
    parameter int SETTLE_TICKS = 16,
    parameter int DIV_W        = 8,
    localparam int N_CH        = N_DEV * CH_PER_DEV,
    localparam int AW          = $clog2(N_CH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_period,
    input  logic             start,
    output logic             busy,
    output logic [AW-1:0]    dc_addr,
    input  logic [DC_W-1:0]  dc_word,
    output logic [AW-1:0]    gs_addr,
    input  logic [GS_W-1:0]  gs_word,
    output logic             ser_out,
    output logic             ser_clk,
    output logic             latch,
    output logic             blank,
    output logic             prog_sel,
    output logic             dc_prog,
    output logic             pwm_clk
);
    localparam int PW = $clog2(PWM_TICKS);
    localparam int SW = $clog2(SETTLE_TICKS + 1);

    typedef struct packed {
        lcc_state_e    st;
        logic          sclk;
        logic          gsclk;
        logic          sin;
        logic          xlat;
        logic          blank;
        logic          prog;
        logic          dcprog;
        logic          busy;
        logic          first;
        logic          shift;
        logic [PW-1:0] pwm;
        logic [SW-1:0] settle;
    } regs_t;

    localparam regs_t R_RST = '{
        st: ST_SETTLE, sclk: 1'b0, gsclk: 1'b0, sin: 1'b0, xlat: 1'b0,
        blank: 1'b1, prog: 1'b1, dcprog: 1'b0, busy: 1'b1, first: 1'b0,
        shift: 1'b0, pwm: '0, settle: '0
    };

    regs_t r_d, r_q;
    logic  tick;
    logic  dc_adv, gs_adv, gs_clr;
    logic  dc_bit, dc_last, dc_done;
    logic  gs_bit, gs_last, gs_done;

    lcc_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .half  (half_period),
        .tick  (tick)
    );

    lcc_word_ser #(.W(DC_W), .N(N_CH), .AW(AW)) u_dc_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .adv   (dc_adv),
        .word  (dc_word),
        .addr  (dc_addr),
        .bit_o (dc_bit),
        .last  (dc_last),
        .done  (dc_done)
    );

    lcc_word_ser #(.W(GS_W), .N(N_CH), .AW(AW)) u_gs_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (gs_clr),
        .adv   (gs_adv),
        .word  (gs_word),
        .addr  (gs_addr),
        .bit_o (gs_bit),
        .last  (gs_last),
        .done  (gs_done)
    );

    always_comb begin
        r_d    = r_q;
        dc_adv = 1'b0;
        gs_adv = 1'b0;
        gs_clr = 1'b0;
        unique case (r_q.st)
            ST_SETTLE: if (tick) begin
                if (r_q.settle == SW'(SETTLE_TICKS - 1)) begin
                    r_d.dcprog = 1'b1;
                    r_d.prog   = 1'b1;
                    r_d.st     = ST_DC_LO;
                end else begin
                    r_d.settle = r_q.settle + SW'(1);
                end
            end
            ST_DC_LO: if (tick) begin
                r_d.sclk = 1'b0;
                r_d.sin  = dc_bit;
                r_d.st   = ST_DC_HI;
            end
            ST_DC_HI: if (tick) begin
                r_d.sclk = 1'b1;
                dc_adv   = 1'b1;
                r_d.st   = dc_last ? ST_DC_END : ST_DC_LO;
            end
            ST_DC_END: if (tick) begin
                r_d.sclk = 1'b0;
                r_d.st   = ST_DC_LAT_ON;
            end
            ST_DC_LAT_ON: if (tick) begin
                r_d.xlat = 1'b1;
                r_d.st   = ST_DC_LAT_MID;
            end
            ST_DC_LAT_MID: if (tick) begin
                r_d.st = ST_DC_LAT_OFF;
            end
            ST_DC_LAT_OFF: if (tick) begin
                r_d.xlat = 1'b0;
                r_d.st   = ST_DC_EXIT;
            end
            ST_DC_EXIT: if (tick) begin
                r_d.dcprog = 1'b0;
                r_d.busy   = 1'b0;
                r_d.st     = ST_IDLE;
            end
            ST_IDLE: if (start) begin
                r_d.busy  = 1'b1;
                r_d.blank = 1'b0;
                r_d.pwm   = '0;
                gs_clr    = 1'b1;
                if (r_q.prog) begin
                    r_d.prog  = 1'b0;
                    r_d.first = 1'b1;
                end
                r_d.st = ST_GS_LO;
            end
            ST_GS_LO: if (tick) begin
                r_d.sclk  = 1'b0;
                r_d.gsclk = 1'b0;
                r_d.shift = !gs_done;
                r_d.sin   = gs_done ? 1'b0 : gs_bit;
                r_d.st    = ST_GS_HI;
            end
            ST_GS_HI: if (tick) begin
                r_d.gsclk = 1'b1;
                r_d.sclk  = r_q.shift;
                gs_adv    = r_q.shift;
                if (r_q.pwm == PW'(PWM_TICKS - 1)) begin
                    r_d.st = ST_GS_END;
                end else begin
                    r_d.pwm = r_q.pwm + PW'(1);
                    r_d.st  = ST_GS_LO;
                end
            end
            ST_GS_END: if (tick) begin
                r_d.sclk  = 1'b0;
                r_d.gsclk = 1'b0;
                r_d.blank = 1'b1;
                r_d.st    = ST_LAT_ON;
            end
            ST_LAT_ON: if (tick) begin
                r_d.xlat = 1'b1;
                r_d.st   = ST_LAT_MID;
            end
            ST_LAT_MID: if (tick) begin
                r_d.st = ST_LAT_OFF;
            end
            ST_LAT_OFF: if (tick) begin
                r_d.xlat = 1'b0;
                if (r_q.first) begin
                    r_d.st = ST_XTRA_HI;
                end else begin
                    r_d.busy = 1'b0;
                    r_d.st   = ST_IDLE;
                end
            end
            ST_XTRA_HI: if (tick) begin
                r_d.sclk = 1'b1;
                r_d.st   = ST_XTRA_LO;
            end
            ST_XTRA_LO: if (tick) begin
                r_d.sclk  = 1'b0;
                r_d.first = 1'b0;
                r_d.busy  = 1'b0;
                r_d.st    = ST_IDLE;
            end
            default: r_d = R_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= R_RST;
        else        r_q <= r_d;
    end

    assign busy     = r_q.busy;
    assign ser_out  = r_q.sin;
    assign ser_clk  = r_q.sclk;
    assign latch    = r_q.xlat;
    assign blank    = r_q.blank;
    assign prog_sel = r_q.prog;
    assign dc_prog  = r_q.dcprog;
    assign pwm_clk  = r_q.gsclk;

    AST_LATCH_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.xlat |-> r_q.blank); // R7
    AST_DC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.dcprog |-> r_q.prog); // R2
    AST_SIN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.sclk) |-> $stable(r_q.sin)); // R10
    AST_PWM_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.gsclk) |-> !r_q.blank); // R5
    AST_BLANK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.blank |-> r_q.busy); // R9
    AST_EXTRA_ONLY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(r_q.sclk) && r_q.blank) |-> (r_q.dcprog || r_q.first)); // R8
    AST_DC_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> dc_done); // R4
    AST_GS_FINAL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (gs_adv && gs_last) |=> gs_done); // R6

endmodule

// File: tb/sim_led_chain_ctrl.sv
module sim_led_chain_ctrl;
    localparam int N_DEV  = 2;
    localparam int N_CH   = N_DEV * 16;
    localparam int GS_W   = 12;
    localparam int DC_W   = 6;
    localparam int PWM    = 4096;
    localparam int SETTLE = 8;
    localparam int DIV_W  = 4;
    localparam int AW     = $clog2(N_CH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DIV_W-1:0] half = 4'd1;
    logic busy, ser_out, ser_clk, latch, blank, prog_sel, dc_prog, pwm_clk;
    logic [AW-1:0] dc_addr, gs_addr;
    logic [DC_W-1:0] dc_word;
    logic [GS_W-1:0] gs_word;
    logic [DC_W-1:0] dc_mem [N_CH];
    logic [GS_W-1:0] gs_mem [N_CH];

    always #2 clk = ~clk;

    always_comb dc_word = (int'(dc_addr) < N_CH) ? dc_mem[dc_addr] : '0;
    always_comb gs_word = (int'(gs_addr) < N_CH) ? gs_mem[gs_addr] : '0;

    led_chain_ctrl #(
        .N_DEV(N_DEV), .GS_W(GS_W), .DC_W(DC_W), .PWM_TICKS(PWM),
        .SETTLE_TICKS(SETTLE), .DIV_W(DIV_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .half_period(half), .start(start),
        .busy(busy), .dc_addr(dc_addr), .dc_word(dc_word),
        .gs_addr(gs_addr), .gs_word(gs_word), .ser_out(ser_out),
        .ser_clk(ser_clk), .latch(latch), .blank(blank),
        .prog_sel(prog_sel), .dc_prog(dc_prog), .pwm_clk(pwm_clk)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver side of the scoreboard: expected serial stream, word 0 first, LSB first.
    task automatic push_dc();
        for (int i = 0; i < N_CH; i++)
            for (int b = 0; b < DC_W; b++) exp_q.push_back(dc_mem[i][b]);
    endtask

    task automatic push_gs();
        for (int i = 0; i < N_CH; i++)
            for (int b = 0; b < GS_W; b++) exp_q.push_back(gs_mem[i][b]);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // Monitor: models the chain's shift register and frame timing.
    logic prev_sclk = 0, prev_sin = 0, prev_xlat = 0, prev_blank = 1;
    logic prev_gsclk = 0, prev_busy = 1;
    bit   post_latch = 0;
    int   bits_cnt = 0, extra_cnt = 0, latch_idx = 0, gs_rises = 0;
    int   lat_w = 0, gs_hi_w = 0, meas_hi = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            int eff_half;
            eff_half = (half == 0) ? 1 : int'(half);
            if (ser_clk && !prev_sclk) begin
                if (post_latch) begin
                    extra_cnt++;
                end else begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6", "surplus shift edge", bits_cnt, 0);
                    end else begin
                        bit e;
                        e = exp_q.pop_front();
                        check(ser_out == e, (latch_idx == 0) ? "R3" : "R6",
                              "serial bit", int'(ser_out), int'(e));
                    end
                    bits_cnt++;
                    if (latch_idx == 0 && bits_cnt == 1)
                        check(dc_prog && prog_sel, "R2", "correction mode at first bit",
                              int'(dc_prog && prog_sel), 1);
                end
                check(ser_out == prev_sin, "R10", "data setup before shift edge",
                      int'(ser_out), int'(prev_sin));
            end
            if (pwm_clk && !prev_gsclk) gs_rises++;
            if (pwm_clk) gs_hi_w++;
            else if (prev_gsclk) begin
                meas_hi = gs_hi_w;
                gs_hi_w = 0;
            end
            if (latch && !prev_xlat) begin
                check(blank == 1'b1, "R7", "blank high at latch", int'(blank), 1);
                if (latch_idx == 0) begin
                    check(bits_cnt == N_CH * DC_W, "R3", "correction bit count",
                          bits_cnt, N_CH * DC_W);
                end else begin
                    check(bits_cnt == N_CH * GS_W, "R6", "grayscale bit count",
                          bits_cnt, N_CH * GS_W);
                    check(gs_rises == PWM, "R5", "PWM ticks per frame", gs_rises, PWM);
                end
                check(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
                bits_cnt   = 0;
                post_latch = 1;
                lat_w      = 0;
            end
            if (latch) lat_w++;
            else if (prev_xlat) begin
                check(lat_w >= 2 * eff_half, "R7", "latch width", lat_w, 2 * eff_half);
                latch_idx++;
                if (latch_idx == 1)
                    check(dc_prog == 1'b1, "R4", "correction enable held through latch",
                          int'(dc_prog), 1);
            end
            if (!blank && prev_blank) begin
                post_latch = 0;
                extra_cnt  = 0;
                gs_rises   = 0;
            end
            if (!busy && prev_busy) begin
                int exp_extra;
                exp_extra = (latch_idx == 2) ? 1 : 0;
                check(extra_cnt == exp_extra, "R8", "extra shift clocks after latch",
                      extra_cnt, exp_extra);
            end
        end
        prev_sclk  = ser_clk;
        prev_sin   = ser_out;
        prev_xlat  = latch;
        prev_blank = blank;
        prev_gsclk = pwm_clk;
        prev_busy  = busy;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N_CH; i++) dc_mem[i] = DC_W'((i * 5 + 3) & 63);
        for (int i = 0; i < N_CH; i++) gs_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset levels
        check(!ser_clk && !pwm_clk && prog_sel && !latch && blank && !dc_prog && busy,
              "R1", "reset output levels",
              {ser_clk, pwm_clk, prog_sel, latch, blank, dc_prog, busy}, 7'b0010101);
        push_dc();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!ser_clk && !dc_prog, "R2", "quiet during settle",
              int'(ser_clk | dc_prog), 0);
        repeat (10) @(negedge clk);
        pulse_start();                       // R9: ignored while correction runs
        wait_idle();
        check(!dc_prog && prog_sel, "R4", "after correction: enable low, select high",
              {dc_prog, prog_sel}, 2'b01);

        // Frame 1: first frame after correction
        for (int i = 0; i < N_CH; i++) gs_mem[i] = GS_W'((i * 291 + 17) & 12'hFFF);
        push_gs();
        pulse_start();
        @(negedge clk);
        check(busy && !blank, "R5", "frame started", {busy, blank}, 2'b10);
        check(!prog_sel, "R8", "select dropped on first frame", int'(prog_sel), 0);
        repeat (500) @(negedge clk);
        pulse_start();                       // R9: ignored mid-frame
        wait_idle();
        repeat (40) @(negedge clk);
        check(!busy && blank, "R9", "no frame from ignored start", {busy, blank}, 2'b01);

        // Frame 2: slower clock
        half = 4'd3;
        for (int i = 0; i < N_CH; i++) gs_mem[i] = i[0] ? 12'hFFF : 12'hA5A;
        push_gs();
        pulse_start();
        wait_idle();
        check(meas_hi == 3, "R10", "PWM high width at half 3", meas_hi, 3);
        check(!prog_sel, "R8", "select stays low", int'(prog_sel), 0);

        // Frame 3: zero half-period counts as one
        half = 4'd0;
        for (int i = 0; i < N_CH; i++) gs_mem[i] = ~GS_W'(i * 77);
        push_gs();
        pulse_start();
        wait_idle();
        check(meas_hi == 1, "R10", "PWM high width at half 0", meas_hi, 1);

        repeat (10) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule